// File: doc/BRIEF.md
# One-Shot Pulse Timer with Down-Counter

This block is one timer channel that turns an external start event into a single output pulse. The pulse width is a whole number of count-clock periods. Before a shot, software loads a 16-bit count, either directly or through a reload register, and sets an arm bit. An arriving start trigger makes the channel wait for the next count-clock enable. On that enable the output goes high, and each later enable takes one from the count.

When the count steps from one to zero, the output falls, the arm bit clears itself and a sticky end flag rises. The counter then holds zero, so the channel cannot fire again until it is given a new count and armed again. A terminate trigger ends the pulse at any time. It disarms the channel and freezes the count where it stands, and it does not set the end flag, so the pulse can be cut off on demand.

The count clock is not a free clock. It is the logical AND of two prescaler enable strobes, both taken on the peripheral clock.

Top module: `oneshot_down_timer`

## Requirements
- R1: The count-clock enable is the AND of `pre1_en` and `pre2_en`. If either one is low, the channel does not start a pulse and `cnt_val` does not change.
- R2: A start trigger seen while armed makes the channel wait. On the first count-clock enable after the trigger edge, `pulse_out` rises and `cnt_val` keeps its value.
- R3: While the pulse is high, each count-clock enable subtracts one from the count. On the enable that takes the count from 1 to 0, `pulse_out` falls. A count of N therefore gives a pulse of N count-clock periods.
- R4: When a shot completes, `armed` clears by itself and `cnt_val` holds 0. Later start triggers produce no pulse until the channel is armed again.
- R5: The same edge that ends a shot sets `end_flag`. The flag stays set until `flag_clr` is pulsed. If setting and clearing fall in the same cycle, setting wins.
- R6: A start trigger while `armed` is 0 has no effect.
- R7: With `HAS_RELOAD` = 1, asserting `arm_set` while disarmed copies the reload register into the counter. If `cnt_wr` is asserted in the same cycle, the written value is loaded instead.
- R8: A terminate trigger has the following effects at the next edge:
  - `pulse_out` is forced low and `armed` is cleared.
  - The count freezes at its present value.
  - `end_flag` is not set.
  - It takes precedence over a final count-clock enable in the same cycle.
- R9: A `cnt_wr` during a pulse loads the new count at the next edge. The pulse continues, and any count-clock enable in that cycle does not decrement.
- R10: If the count is 0 on the starting count-clock enable, no pulse is produced. `armed` clears and `end_flag` is set.
- R11: While `rst_n` is low at a clock edge, the channel resets to:
  - `pulse_out`, `armed` and `end_flag` at 0;
  - counter and reload register at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pre1_en | input | 1 | First prescaler enable strobe |
| pre2_en | input | 1 | Second prescaler enable strobe |
| start_trig | input | 1 | Start trigger, one cycle per event |
| term_trig | input | 1 | Terminate trigger, cuts the pulse |
| arm_set | input | 1 | Sets the arm bit (and loads reload value) |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write data |
| rld_wr | input | 1 | Reload register write strobe |
| rld_wdata | input | CNT_W | Reload register write data |
| flag_clr | input | 1 | Clears the end flag |
| pulse_out | output | 1 | One-shot pulse output |
| armed | output | 1 | Arm bit state |
| end_flag | output | 1 | Sticky end-of-shot flag |
| cnt_val | output | CNT_W | Current counter value |

## Verification
The count can reach its end and a terminate trigger can arrive in the same cycle. The bench provokes this by running a shot down to a count of 1 with single manual count-clock enables, then asserting `term_trig` together with the final enable. The result is judged at the ports on the next sample. The pulse must be low and the channel disarmed, the count must still read 1, and `end_flag` must stay clear, which shows that the terminate trigger took precedence. A second collision pairs a counter write with a count-clock enable. The bench expects the written value rather than that value less one.

// File: rtl/oneshot_pkg.sv
// Package: shared types for the one-shot timer channel.
// Assumes: nothing beyond IEEE 1800-2017.
package oneshot_pkg;
    typedef enum logic [1:0] {
        OS_IDLE = 2'd0,   // not running, may or may not be armed
        OS_WAIT = 2'd1,   // start seen, waiting for a count-clock enable
        OS_RUN  = 2'd2    // pulse high, counting down
    } os_state_t;
endpackage

// File: rtl/os_tick_gate.sv
// Module: os_tick_gate
// Combines the two prescaler stage strobes into the single count-clock
// enable used by the channel.
// Assumes: both strobes are synchronous to clk and one cycle wide.
module os_tick_gate (
    input  logic pre1_en,
    input  logic pre2_en,
    output logic tick
);
    // Both stages must agree for a count-clock enable.
    always_comb begin
        tick = pre1_en & pre2_en;
    end
endmodule

// File: rtl/os_down_counter.sv
// Module: os_down_counter
// Loadable down-counter that saturates at zero, with compare outputs.
// Assumes: load has priority over decrement; reset is synchronous active-low.
module os_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         dec_en,
    output logic [W-1:0] count,
    output logic         at_one,
    output logic         at_zero
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Count register: load, else decrement toward zero, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_en)
            count <= load_val;
        else if (dec_en && !at_zero)
            count <= count - ONE;
    end

    // Compare flags for the controller.
    always_comb begin
        at_one  = (count == ONE);
        at_zero = (count == '0);
    end

    assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !load_en && !at_zero) |=> (count == $past(count) - ONE));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_en && !load_en) |=> $stable(count));
endmodule

// File: rtl/os_ctrl.sv
// Module: os_ctrl
// Sequencer for one shot: arm bit, wait-for-tick, run, end detection,
// terminate cutoff and the sticky end flag.
// Assumes: at_one/at_zero describe the counter value before this edge;
// term_trig has priority over every other event.
module os_ctrl
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_trig,
    input  logic term_trig,
    input  logic arm_set,
    input  logic cnt_wr,
    input  logic flag_clr,
    input  logic at_one,
    input  logic at_zero,
    output logic dec_en,
    output logic pulse_q,
    output logic armed_q,
    output logic end_flag_q
);
    os_state_t state_q, state_d;
    logic      armed_d;
    logic      end_set;

    // Next-state decode for the shot sequence.
    always_comb begin
        state_d = state_q;
        armed_d = armed_q;
        end_set = 1'b0;
        dec_en  = 1'b0;
        if (term_trig) begin
            state_d = OS_IDLE;
            armed_d = 1'b0;
        end else begin
            unique case (state_q)
                OS_IDLE: begin
                    if (arm_set)
                        armed_d = 1'b1;
                    if (armed_q && start_trig)
                        state_d = OS_WAIT;
                end
                OS_WAIT: begin
                    if (tick) begin
                        if (at_zero) begin
                            state_d = OS_IDLE;
                            armed_d = 1'b0;
                            end_set = 1'b1;
                        end else begin
                            state_d = OS_RUN;
                        end
                    end
                end
                OS_RUN: begin
                    if (tick && !cnt_wr) begin
                        dec_en = 1'b1;
                        if (at_one || at_zero) begin
                            state_d = OS_IDLE;
                            armed_d = 1'b0;
                            end_set = 1'b1;
                        end
                    end
                end
                default: state_d = OS_IDLE;
            endcase
        end
    end

    // State, arm bit and registered pulse output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
            armed_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
            pulse_q <= (state_d == OS_RUN);
        end
    end

    // Sticky end flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            end_flag_q <= 1'b0;
        else if (end_set)
            end_flag_q <= 1'b1;
        else if (flag_clr)
            end_flag_q <= 1'b0;
    end

    assert_pulse_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> armed_q);

    assert_term_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
        term_trig |=> (!pulse_q && !armed_q));

    assert_term_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (term_trig && !end_flag_q) |=> !end_flag_q);

    assert_disarmed_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |=> !pulse_q);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (end_flag_q && !flag_clr) |=> end_flag_q);

    assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> $past(tick));

    assert_end_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag_q) |-> ($past(tick) && !armed_q));
endmodule

// File: rtl/oneshot_down_timer.sv
// Module: oneshot_down_timer (top)
// One timer channel producing a single pulse whose width is a counted
// number of count-clock enables, with terminate cutoff and optional reload.
// Assumes: all inputs synchronous to clk; strobes are one cycle wide;
// synchronous active-low reset.
module oneshot_down_timer #(
    parameter int CNT_W      = 16,
    parameter bit HAS_RELOAD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre1_en,
    input  logic             pre2_en,
    input  logic             start_trig,
    input  logic             term_trig,
    input  logic             arm_set,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             rld_wr,
    input  logic [CNT_W-1:0] rld_wdata,
    input  logic             flag_clr,
    output logic             pulse_out,
    output logic             armed,
    output logic             end_flag,
    output logic [CNT_W-1:0] cnt_val
);
    logic             tick;
    logic             dec_en;
    logic             at_one, at_zero;
    logic             reload_ld;
    logic             load_en;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] reload_q;

    os_tick_gate u_tick (
        .pre1_en (pre1_en),
        .pre2_en (pre2_en),
        .tick    (tick)
    );

    generate
        if (HAS_RELOAD) begin : g_reload
            // Reload register written by software.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    reload_q <= '0;
                else if (rld_wr)
                    reload_q <= rld_wdata;
            end
            // Copy reload into counter when arming a disarmed channel.
            always_comb begin
                reload_ld = arm_set && !armed && !term_trig;
            end
        end else begin : g_noreload
            // No reload register on this variant.
            always_comb begin
                reload_q  = '0;
                reload_ld = 1'b0;
            end
        end
    endgenerate

    // Counter load source: direct write wins over reload.
    always_comb begin
        load_en  = cnt_wr || reload_ld;
        load_val = cnt_wr ? cnt_wdata : reload_q;
    end

    os_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (load_val),
        .dec_en   (dec_en),
        .count    (cnt_val),
        .at_one   (at_one),
        .at_zero  (at_zero)
    );

    os_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start_trig (start_trig),
        .term_trig  (term_trig),
        .arm_set    (arm_set),
        .cnt_wr     (cnt_wr),
        .flag_clr   (flag_clr),
        .at_one     (at_one),
        .at_zero    (at_zero),
        .dec_en     (dec_en),
        .pulse_q    (pulse_out),
        .armed_q    (armed),
        .end_flag_q (end_flag)
    );

    assert_done_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> (cnt_val == '0 || $past(cnt_wr)));
endmodule

// File: tb/test_oneshot_down_timer.sv
`timescale 1ns/1ps
module test_oneshot_down_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pre1_en = 1'b0, pre2_en = 1'b1;
    logic         start_trig = 1'b0, term_trig = 1'b0, arm_set = 1'b0;
    logic         cnt_wr = 1'b0, rld_wr = 1'b0, flag_clr = 1'b0;
    logic [W-1:0] cnt_wdata = '0, rld_wdata = '0;
    logic         pulse_out, armed, end_flag;
    logic [W-1:0] cnt_val;

    int  n_run = 0, n_fail = 0;
    int  per = 0;        // periodic count-clock enable spacing, 0 = off
    int  ph = 0;
    logic man_tick = 1'b0;
    logic pre2_force = 1'b1;
    logic saw_pulse;

    // Vector table: {count N, enable period D}; expected width = N*D clocks.
    localparam logic [31:0] VEC [6] = '{
        {16'd1, 16'd1}, {16'd5, 16'd1}, {16'd3, 16'd4},
        {16'd8, 16'd2}, {16'd2, 16'd7}, {16'd12, 16'd3}
    };

    always #2.5 clk = ~clk;

    oneshot_down_timer #(.CNT_W(W), .HAS_RELOAD(1'b1)) i_oneshot_down_timer (
        .clk(clk), .rst_n(rst_n), .pre1_en(pre1_en), .pre2_en(pre2_en),
        .start_trig(start_trig), .term_trig(term_trig), .arm_set(arm_set),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .rld_wr(rld_wr),
        .rld_wdata(rld_wdata), .flag_clr(flag_clr), .pulse_out(pulse_out),
        .armed(armed), .end_flag(end_flag), .cnt_val(cnt_val)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: set enables, cross posedge, return at negedge, clear strobes.
    task automatic step();
        pre1_en = man_tick || (per != 0 && (ph % per) == 0);
        pre2_en = pre2_force;
        ph++;
        @(posedge clk);
        @(negedge clk);
        start_trig = 0; term_trig = 0; arm_set = 0; cnt_wr = 0;
        rld_wr = 0; flag_clr = 0; man_tick = 0;
        if (pulse_out) saw_pulse = 1'b1;
    endtask

    task automatic load_and_arm(input logic [W-1:0] v);
        rld_wr = 1; rld_wdata = v; step();
        arm_set = 1; step();
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step(); step();
        // R11 reset state
        check("R11", "pulse", {31'd0, pulse_out}, 0);
        check("R11", "armed", {31'd0, armed}, 0);
        check("R11", "end_flag", {31'd0, end_flag}, 0);
        check("R11", "count", {16'd0, cnt_val}, 0);
        rst_n = 1; step();

        // R6: start while disarmed is ignored
        saw_pulse = 0; per = 1; start_trig = 1; step();
        for (int i = 0; i < 8; i++) step();
        per = 0;
        check("R6", "no pulse when disarmed", {31'd0, saw_pulse}, 0);
        check("R6", "count untouched", {16'd0, cnt_val}, 0);

        // Vector walk: R2/R3/R4/R5/R7
        for (int v = 0; v < 6; v++) begin
            int n, d, width;
            n = int'(VEC[v][31:16]); d = int'(VEC[v][15:0]);
            load_and_arm(W'(n));
            check("R7", "reload copied on arm", {16'd0, cnt_val}, n);
            start_trig = 1; per = d; ph = 0; step();
            width = 0;
            for (int k = 0; k < 400; k++) begin
                step();
                if (pulse_out) width++;
                if (!armed) break;
            end
            per = 0;
            check("R3", "pulse width", width, n * d);
            check("R5", "end flag set", {31'd0, end_flag}, 1);
            check("R4", "count left at 0", {16'd0, cnt_val}, 0);
            check("R4", "auto disarm", {31'd0, armed}, 0);
            flag_clr = 1; step();
            check("R5", "flag cleared", {31'd0, end_flag}, 0);
        end

        // R4: re-trigger without re-arming gives nothing
        saw_pulse = 0; per = 1; start_trig = 1; step();
        for (int i = 0; i < 6; i++) step();
        per = 0;
        check("R4", "no re-fire before re-arm", {31'd0, saw_pulse}, 0);

        // R1: second stage low blocks counting and start
        load_and_arm(16'd4);
        saw_pulse = 0; pre2_force = 0; per = 1; start_trig = 1; step();
        for (int i = 0; i < 8; i++) step();
        per = 0; pre2_force = 1;
        check("R1", "no pulse with stage2 low", {31'd0, saw_pulse}, 0);
        check("R1", "count held", {16'd0, cnt_val}, 4);
        man_tick = 1; step();
        check("R2", "rise on first enable", {31'd0, pulse_out}, 1);
        check("R2", "count kept on start", {16'd0, cnt_val}, 4);
        term_trig = 1; step();

        // R8: terminate mid-pulse
        load_and_arm(16'd6);
        start_trig = 1; step();
        man_tick = 1; step(); man_tick = 1; step(); man_tick = 1; step();
        check("R3", "decremented twice", {16'd0, cnt_val}, 4);
        term_trig = 1; step();
        check("R8", "pulse cut", {31'd0, pulse_out}, 0);
        check("R8", "disarmed", {31'd0, armed}, 0);
        check("R8", "no end flag", {31'd0, end_flag}, 0);
        man_tick = 1; step();
        check("R8", "count frozen", {16'd0, cnt_val}, 4);

        // R8: terminate on the same cycle as the final enable
        load_and_arm(16'd3);
        start_trig = 1; step();
        man_tick = 1; step(); man_tick = 1; step(); man_tick = 1; step();
        check("R3", "count at one", {16'd0, cnt_val}, 1);
        man_tick = 1; term_trig = 1; step();
        check("R8", "collision count stays 1", {16'd0, cnt_val}, 1);
        check("R8", "collision no flag", {31'd0, end_flag}, 0);
        check("R8", "collision pulse low", {31'd0, pulse_out}, 0);

        // R9: write during a pulse, alongside an enable
        load_and_arm(16'd5);
        start_trig = 1; step();
        man_tick = 1; step(); man_tick = 1; step(); man_tick = 1; step();
        cnt_wr = 1; cnt_wdata = 16'd2; man_tick = 1; step();
        check("R9", "written value, no decrement", {16'd0, cnt_val}, 2);
        check("R9", "pulse continues", {31'd0, pulse_out}, 1);
        man_tick = 1; step();
        check("R9", "pulse still high at 1", {31'd0, pulse_out}, 1);
        man_tick = 1; step();
        check("R9", "pulse ends after new count", {31'd0, pulse_out}, 0);
        check("R5", "end flag after write shot", {31'd0, end_flag}, 1);
        for (int i = 0; i < 5; i++) step();
        check("R5", "flag sticky", {31'd0, end_flag}, 1);
        flag_clr = 1; step();
        check("R5", "flag clear", {31'd0, end_flag}, 0);

        // R7: write in the same cycle as arm wins over reload
        rld_wr = 1; rld_wdata = 16'd9; step();
        arm_set = 1; cnt_wr = 1; cnt_wdata = 16'd3; step();
        check("R7", "write beats reload", {16'd0, cnt_val}, 3);
        term_trig = 1; step();

        // R10: start with zero count
        load_and_arm(16'd0);
        saw_pulse = 0; start_trig = 1; step();
        man_tick = 1; step(); step();
        check("R10", "no pulse from zero", {31'd0, saw_pulse}, 0);
        check("R10", "disarmed", {31'd0, armed}, 0);
        check("R10", "end flag", {31'd0, end_flag}, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule